// File: doc/BRIEF.md
# Bus Master Stall Watchdog

This block watches one bus master's transactions and ends any transaction whose target stops answering, or answers only with retries. A 5-bit setting from the master's configuration is scaled by eight to form the number of clock cycles a data phase may last before the watchdog gives up. While a transaction is open, a counter advances on every clock. Each completed data transfer, and the start of a transaction, restarts the counter from zero.

When the counter reaches the terminal count before the target responds, the block raises a master-abort request and a system-error request together for exactly one clock. A setting of zero turns the watchdog off. Retry terminations do not restart the counter, so a target that retries without end is still aborted. A cycle in which the target-ready line is asserted defers expiry by one cycle. Both outputs are registered.

Top module: `mst_stall_watchdog`

## Requirements
- R1: While the synchronous reset is high, and in the first cycle after it, abort_req and serr_req are low.
- R2: With tmr_set equal to 0 latched at the latest restart, no abort_req or serr_req pulse occurs, however long the transaction lasts.
- R3: With a nonzero setting S latched at a restart, the terminal count is L = S*8 (S in the upper five bits of an 8-bit count, lower three bits zero). If nothing else happens, abort_req is first high in the cycle after the L-th rising edge that follows the restart edge.
- R4: A clock edge at which xact_active and xfer_ok are both high restarts the count. Expiry then moves to L edges after that edge.
- R5: serr_req is high in exactly the cycles in which abort_req is high, and each pulse lasts one cycle.
- R6: Retry terminations (retry high) do not restart the count. A transaction answered only with retries is aborted at the same edge as one with no response at all.
- R7: After an expiry, no further pulse is issued until the count is restarted, even if the transaction stays active.
- R8: A rising edge of xact_active restarts the count. While xact_active is low, the count holds at zero and no pulse is issued.
- R9: tmr_set is sampled only at restarts. A change made in the middle of a transaction does not alter the running terminal count, and takes effect at the next restart.
- R10: A clock edge at which trdy is high blocks expiry at that edge. Holding trdy across the expiry point delays the pulse by one cycle per edge held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tmr_set | input | 5 | Timeout setting; 0 disables the watchdog |
| xact_active | input | 1 | High while the master owns an open transaction |
| xfer_ok | input | 1 | A data transfer completed this cycle (initiator and target both ready) |
| trdy | input | 1 | Target-ready seen asserted this cycle |
| retry | input | 1 | Target ended the data phase with a retry |
| abort_req | output | 1 | One-cycle request to end the transaction with a master abort |
| serr_req | output | 1 | One-cycle request to signal a system error |

## Verification
A wrong counter value or a stale latched limit shows at the ports as an abort pulse that comes early or late. Because every expected pulse is tied to the exact edge it must follow, such a fault is caught at the first expiry after it. A fired flag that is stuck or never cleared shows as a repeated pulse during a long stalled transaction, or as a pulse missing after a restart. A restart path that is broken shows as a pulse that ignores an intervening transfer or a setting change. Each of these is detected within one terminal count of the fault.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int DEF_SET_W  = 5;
  localparam int DEF_FRAC_W = 3;

  typedef struct packed {
    logic active;
    logic restart;
    logic trdy;
  } wdg_ctl_t;
endpackage

// File: rtl/wdg_limit_reg.sv
module wdg_limit_reg #(
  parameter int SET_W  = wdg_pkg::DEF_SET_W,
  parameter int FRAC_W = wdg_pkg::DEF_FRAC_W,
  localparam int CNT_W = SET_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [SET_W-1:0] tmr_set,
  output logic [CNT_W-1:0] lim_m1,
  output logic             armed
);
  logic [CNT_W-1:0] limit_q;

  // The setting is captured only at restarts, so mid-transaction edits wait.
  always_ff @(posedge clk) begin
    if (rst)          limit_q <= '0;
    else if (restart) limit_q <= {tmr_set, {FRAC_W{1'b0}}};
  end

  assign armed  = (limit_q != '0);
  assign lim_m1 = limit_q - 1'b1;
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int CNT_W = wdg_pkg::DEF_SET_W + wdg_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  wdg_pkg::wdg_ctl_t ctl,
  input  logic              armed,
  input  logic [CNT_W-1:0]  lim_m1,
  output logic [CNT_W-1:0]  cnt
);
  always_ff @(posedge clk) begin
    if (rst || !ctl.active)          cnt <= '0;
    else if (ctl.restart)            cnt <= '0;
    else if (armed && cnt != lim_m1) cnt <= cnt + 1'b1;
  end

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ctl.active && ctl.restart) |=> (cnt == '0)); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !ctl.active |=> (cnt == '0)); // R8
endmodule

// File: rtl/wdg_expiry.sv
module wdg_expiry #(
  parameter int CNT_W = wdg_pkg::DEF_SET_W + wdg_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  wdg_pkg::wdg_ctl_t ctl,
  input  logic              armed,
  input  logic [CNT_W-1:0]  lim_m1,
  input  logic [CNT_W-1:0]  cnt,
  output logic              abort_q,
  output logic              serr_q
);
  logic fired_q;
  logic fire;

  assign fire = ctl.active && !ctl.restart && armed && !fired_q &&
                !ctl.trdy && (cnt == lim_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      fired_q <= 1'b0;
      abort_q <= 1'b0;
      serr_q  <= 1'b0;
    end else begin
      abort_q <= fire;
      serr_q  <= fire;
      if (!ctl.active || ctl.restart) fired_q <= 1'b0;
      else if (fire)                  fired_q <= 1'b1;
    end
  end

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    abort_q |=> !abort_q); // R7
  AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !armed |=> !abort_q); // R2
  always_comb begin
    AST_SERR_PAIR: assert (rst || abort_q == serr_q); // R5
  end
endmodule

// File: rtl/mst_stall_watchdog.sv
module mst_stall_watchdog #(
  parameter int SET_W  = wdg_pkg::DEF_SET_W,
  parameter int FRAC_W = wdg_pkg::DEF_FRAC_W,
  localparam int CNT_W = SET_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] tmr_set,
  input  logic             xact_active,
  input  logic             xfer_ok,
  input  logic             trdy,
  input  logic             retry,
  output logic             abort_req,
  output logic             serr_req
);
  logic              act_q;
  logic              armed;
  logic [CNT_W-1:0]  lim_m1;
  logic [CNT_W-1:0]  cnt;
  wdg_pkg::wdg_ctl_t ctl;
  logic              retry_unused;

  // Retries deliberately do not restart the count (R6).
  assign retry_unused = retry;

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= xact_active;
  end

  assign ctl.active  = xact_active;
  assign ctl.restart = xact_active && (!act_q || xfer_ok);
  assign ctl.trdy    = trdy;

  wdg_limit_reg #(.SET_W(SET_W), .FRAC_W(FRAC_W)) u_limit (
    .clk(clk), .rst(rst), .restart(ctl.restart), .tmr_set(tmr_set),
    .lim_m1(lim_m1), .armed(armed));

  wdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .ctl(ctl), .armed(armed), .lim_m1(lim_m1),
    .cnt(cnt));

  wdg_expiry #(.CNT_W(CNT_W)) u_exp (
    .clk(clk), .rst(rst), .ctl(ctl), .armed(armed), .lim_m1(lim_m1),
    .cnt(cnt), .abort_q(abort_req), .serr_q(serr_req));

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !xact_active |=> !abort_req); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !abort_req && !serr_req); // R1
endmodule

// File: tb/mst_stall_watchdog_tb_top.sv
module mst_stall_watchdog_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] tmr_set = '0;
  logic       xact_active = 1'b0;
  logic       xfer_ok = 1'b0;
  logic       trdy = 1'b0;
  logic       retry = 1'b0;
  logic       abort_req;
  logic       serr_req;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int seen   = 0;
  int   exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mst_stall_watchdog dut_i (
    .clk(clk), .rst(rst), .tmr_set(tmr_set), .xact_active(xact_active),
    .xfer_ok(xfer_ok), .trdy(trdy), .retry(retry),
    .abort_req(abort_req), .serr_req(serr_req));

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic expect_pulse(int at, string tag);
    exp_q.push_back(at);
    tag_q.push_back(tag);
  endtask

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic start_xact(logic [4:0] s, output int e0);
    @(negedge clk);
    tmr_set = s;
    xact_active = 1'b1;
    e0 = cyc + 1;
  endtask

  task automatic end_xact(int gap);
    @(negedge clk);
    xact_active = 1'b0;
    retry = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic pulse_xfer(int edge_at);
    wait_to(edge_at - 1);
    xfer_ok = 1'b1;
    @(negedge clk);
    xfer_ok = 1'b0;
  endtask

  // Monitor: compare every observed pulse against the scoreboard queue.
  always @(negedge clk) begin
    if (!rst && (abort_req || serr_req)) begin
      seen++;
      check(abort_req && serr_req, "R5", serr_req, abort_req);
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected pulse", cyc, -1);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(cyc == e, t, cyc, e);
      end
    end
  end

  initial begin
    int e0;
    int e1;
    int s0;
    repeat (3) @(negedge clk);
    check(abort_req == 1'b0, "R1 abort in reset", abort_req, 0);
    check(serr_req == 1'b0, "R1 serr in reset", serr_req, 0);
    rst = 1'b0;
    @(negedge clk);
    check(abort_req == 1'b0 && serr_req == 1'b0, "R1 after reset", abort_req, 0);

    // R3 basic expiry, setting 1 -> 8 cycles
    start_xact(5'd1, e0);
    expect_pulse(e0 + 8, "R3");
    wait_to(e0 + 12);
    end_xact(3);

    // R2 disabled
    s0 = seen;
    start_xact(5'd0, e0);
    wait_to(e0 + 300);
    end_xact(3);
    check(seen == s0, "R2 pulses while disabled", seen - s0, 0);

    // R4 restart on transfer, setting 2 -> 16
    start_xact(5'd2, e0);
    pulse_xfer(e0 + 10);
    expect_pulse(e0 + 26, "R4");
    wait_to(e0 + 30);
    end_xact(3);

    // R6 continuous retry, then R7 no repeat, then restart fires again
    start_xact(5'd1, e0);
    retry = 1'b1;
    expect_pulse(e0 + 8, "R6");
    s0 = seen;
    wait_to(e0 + 110);
    check(seen == s0 + 1, "R7 single pulse", seen - s0, 1);
    pulse_xfer(e0 + 112);
    expect_pulse(e0 + 120, "R7 after restart");
    wait_to(e0 + 124);
    end_xact(3);

    // R10 trdy held over expiry point for three edges
    start_xact(5'd1, e0);
    wait_to(e0 + 7);
    trdy = 1'b1;
    wait_to(e0 + 10);
    trdy = 1'b0;
    expect_pulse(e0 + 11, "R10");
    wait_to(e0 + 14);
    end_xact(3);

    // R8 idle gap clears the count
    s0 = seen;
    start_xact(5'd1, e0);
    wait_to(e0 + 4);
    xact_active = 1'b0;
    repeat (3) @(negedge clk);
    xact_active = 1'b1;
    e1 = cyc + 1;
    expect_pulse(e1 + 8, "R8");
    wait_to(e1 + 4);
    check(seen == s0, "R8 no pulse across gap", seen - s0, 0);
    wait_to(e1 + 12);
    end_xact(3);

    // R9 setting change mid-transaction ignored until restart
    start_xact(5'd4, e0);
    wait_to(e0 + 5);
    tmr_set = 5'd1;
    expect_pulse(e0 + 32, "R9 running count kept");
    wait_to(e0 + 36);
    end_xact(3);
    start_xact(5'd4, e1);
    wait_to(e1 + 3);
    tmr_set = 5'd1;
    pulse_xfer(e1 + 6);
    expect_pulse(e1 + 14, "R9 new setting at restart");
    wait_to(e1 + 18);
    end_xact(3);

    // R3 largest setting 31 -> 248
    start_xact(5'd31, e0);
    expect_pulse(e0 + 248, "R3 max setting");
    wait_to(e0 + 252);
    end_xact(3);

    check(exp_q.size() == 0, "R3 missing pulses", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule